// File: doc/BRIEF.md
# Dual-Mode Eight-Bit Timer/Counter

This block is an 8-bit timer/counter with two operating modes, selected by one mode input. In reload mode the low count byte advances and, whenever it passes 0xFF, it takes its next value from the high byte and raises the first overflow flag. The count period is therefore set by the value software places in the high byte. In split mode the two bytes are independent 8-bit timers. The low byte keeps every control it has in reload mode. The high byte always counts the divided clock and uses the second run input and the second overflow flag.

The count source of the low byte is either the peripheral clock divided by six or falling edges on an external count pin. Counting is further qualified by a run input and an optional gate pin. A CPU write port loads either byte. The two overflow flags drive interrupt requests. Each flag stays set until software clears it or the interrupt controller acknowledges it.

Top module: `tmr8_dual`

## Requirements
- R1: While `rst` is high at a clock edge, both count bytes and both overflow flags go to 0, and the divide-by-six prescaler restarts from its first phase.
- R2: With `src_pin` = 0 (clock source), the low byte advances by exactly one on every sixth clock cycle, from a free-running prescaler, so any 60 consecutive enabled cycles add exactly 10.
- R3: With `src_pin` = 1 (pin source), the pin passes through a two-flop synchronizer. Each 1-to-0 transition adds exactly one to the low byte, and the new value is visible three clock edges after the pin falls. Rising edges and steady levels add nothing.
- R4: The low byte counts only while `run_a` = 1 and either `gate_en` = 0 or `gate_pin` = 1. Otherwise it holds its value.
- R5: In reload mode (`split_mode` = 0), a count at 0xFF loads the low byte with `high_q` and sets `ovf_flag[0]`. In clock-source mode this gives one overflow every 6 × (256 − reload) cycles.
- R6: In reload mode the high byte changes only through CPU writes, and `run_b` never sets `ovf_flag[1]`.
- R7: In split mode (`split_mode` = 1), the low byte wraps from 0xFF to 0x00 and sets `ovf_flag[0]`, under the same source, run and gate rules as in reload mode.
- R8: In split mode the high byte advances once per prescaler pulse while `run_b` = 1. It ignores `src_pin`, `gate_en`, `cnt_pin` and `gate_pin`. It wraps from 0xFF to 0x00 and sets `ovf_flag[1]`, which gives a period of 6 × 256 cycles from zero.
- R9: Each overflow flag (bit 0 for the low byte, bit 1 for the high byte) stays set until a cycle with `flag_clr[i]` or `irq_ack[i]` high clears it. An overflow in that same cycle leaves it set.
- R10: A CPU write (`wr_en` = 1, `wr_high` selects the high byte when 1, the low byte when 0) loads `wr_data` into that byte at the next edge. In that cycle the write overrides any count or reload of the byte and suppresses that byte's overflow.
- R11: `low_q` and `high_q` always show the current register contents of the two bytes, and `ovf_flag` shows the current flag state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| split_mode | input | 1 | 0 = reload mode, 1 = split mode |
| src_pin | input | 1 | Low byte source: 0 = clock/6, 1 = count pin |
| gate_en | input | 1 | When 1, the low byte also needs gate_pin high |
| run_a | input | 1 | Run enable for the low byte |
| run_b | input | 1 | Run enable for the high byte in split mode |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| gate_pin | input | 1 | External gate pin |
| wr_en | input | 1 | CPU write strobe |
| wr_high | input | 1 | CPU write target: 1 = high byte, 0 = low byte |
| wr_data | input | 8 | CPU write data |
| flag_clr | input | 2 | CPU clear strobes for the overflow flags |
| irq_ack | input | 2 | Interrupt-acknowledge strobes for the overflow flags |
| low_q | output | 8 | Low count byte |
| high_q | output | 8 | High byte (reload value or second timer) |
| ovf_flag | output | 2 | Overflow flags: bit 0 low byte, bit 1 high byte |

## Verification
The low byte is driven three ways. The first is the clock source with the gate open, shut and unused, which separates run qualification from gate qualification. The second is the pin source with single falling and rising edges, which pins down the synchronizer latency and shows that only falls count. The third is long random runs in both modes, where pin noise, CPU writes biased toward 0xFF and random clears collide with counts and overflows. Overflow spacing is measured in reload mode with a nonzero reload value and in split mode on the high byte with its pins held against it. This separates a reload from a plain wrap and shows the high byte's independence from the pin controls.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic {
        MODE_RELOAD = 1'b0,
        MODE_SPLIT  = 1'b1
    } tmr_mode_e;

    typedef enum logic {
        SRC_CLOCK = 1'b0,
        SRC_PIN   = 1'b1
    } tmr_src_e;

    typedef struct packed {
        tmr_mode_e mode;
        tmr_src_e  src;
        logic      gate_en;
        logic      run_a;
        logic      run_b;
    } tmr_ctrl_t;

    // Run qualification shared by the low byte in both modes
    function automatic logic gate_open(input logic run, input logic gate_en,
                                       input logic gate_pin);
        return run && (!gate_en || gate_pin);
    endfunction

endpackage

// File: rtl/tmr8_prescale.sv
// Free-running modulo-DIV counter; tick is high for one cycle in DIV (R2)
module tmr8_prescale #(
    parameter int unsigned DIV = 6
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase;

    assign tick = (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst)       phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + 1'b1;
    end
endmodule

// File: rtl/tmr8_edge_sync.sv
// STAGES-flop synchronizer plus one history flop; fall marks a 1-to-0 step (R3)
module tmr8_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic [STAGES:0] chain;

    assign fall = chain[STAGES] & ~chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], pin};
    end
endmodule

// File: rtl/tmr8_byte.sv
// One count byte: CPU write first, then count with wrap/reload (R10)
module tmr8_byte #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         inc,
    input  logic [W-1:0] wrap_val,
    output logic [W-1:0] q,
    output logic         ovf
);
    logic at_top;

    assign at_top = (q == '1);
    assign ovf    = inc && !wr && at_top;

    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (wr)     q <= wr_data;
        else if (inc)    q <= at_top ? wrap_val : q + 1'b1;
    end
endmodule

// File: rtl/tmr8_flag.sv
// Sticky overflow flag; a set in the clearing cycle wins (R9)
module tmr8_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set | (q & ~clr);
    end
endmodule

// File: rtl/tmr8_dual.sv
module tmr8_dual
    import tmr8_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter int unsigned DIV  = 6,
    parameter int unsigned SYNC = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         split_mode,
    input  logic         src_pin,
    input  logic         gate_en,
    input  logic         run_a,
    input  logic         run_b,
    input  logic         cnt_pin,
    input  logic         gate_pin,
    input  logic         wr_en,
    input  logic         wr_high,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   flag_clr,
    input  logic [1:0]   irq_ack,
    output logic [W-1:0] low_q,
    output logic [W-1:0] high_q,
    output logic [1:0]   ovf_flag
);
    localparam int unsigned NFLAG = 2;

    tmr_ctrl_t        ctl;
    logic             tick;
    logic             pin_fall;
    logic             lo_inc;
    logic             hi_inc;
    logic             lo_ovf;
    logic             hi_ovf;
    logic             wr_lo;
    logic             wr_hi;
    logic [W-1:0]     lo_wrap;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_kill;

    always_comb begin
        ctl.mode    = split_mode ? MODE_SPLIT : MODE_RELOAD;
        ctl.src     = src_pin ? SRC_PIN : SRC_CLOCK;
        ctl.gate_en = gate_en;
        ctl.run_a   = run_a;
        ctl.run_b   = run_b;
    end

    tmr8_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    tmr8_edge_sync #(.STAGES(SYNC)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (cnt_pin),
        .fall (pin_fall)
    );

    // R2 R3 R4 R7: low byte source and qualification; R8: high byte in split mode
    always_comb begin
        lo_inc  = gate_open(ctl.run_a, ctl.gate_en, gate_pin)
                  && ((ctl.src == SRC_PIN) ? pin_fall : tick);
        hi_inc  = (ctl.mode == MODE_SPLIT) && ctl.run_b && tick;
        lo_wrap = (ctl.mode == MODE_SPLIT) ? '0 : high_q;   // R5 reload source
        wr_lo   = wr_en && !wr_high;
        wr_hi   = wr_en && wr_high;
    end

    tmr8_byte #(.W(W)) u_lo (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_lo),
        .wr_data  (wr_data),
        .inc      (lo_inc),
        .wrap_val (lo_wrap),
        .q        (low_q),
        .ovf      (lo_ovf)
    );

    tmr8_byte #(.W(W)) u_hi (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_hi),
        .wr_data  (wr_data),
        .inc      (hi_inc),
        .wrap_val ('0),
        .q        (high_q),
        .ovf      (hi_ovf)
    );

    assign flag_set  = {hi_ovf, lo_ovf};
    assign flag_kill = flag_clr | irq_ack;

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            tmr8_flag u_flag (
                .clk (clk),
                .rst (rst),
                .set (flag_set[i]),
                .clr (flag_kill[i]),
                .q   (ovf_flag[i])
            );
        end
    endgenerate
endmodule

// File: rtl/tmr8_dual_chk.sv
module tmr8_dual_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         split_mode,
    input logic         run_b,
    input logic         wr_en,
    input logic         wr_high,
    input logic [W-1:0] wr_data,
    input logic [1:0]   flag_clr,
    input logic [1:0]   irq_ack,
    input logic [W-1:0] low_q,
    input logic [W-1:0] high_q,
    input logic [1:0]   ovf_flag,
    input logic         tick,
    input logic         lo_ovf,
    input logic         hi_ovf
);
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);                                                  // R2
    AST_WR_LOW_WINS: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && !wr_high) |-> low_q == $past(wr_data));            // R10
    AST_WR_HIGH_WINS: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && wr_high) |-> high_q == $past(wr_data));            // R10
    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (rst)
        $past(lo_ovf && !split_mode) |-> low_q == $past(high_q));         // R5
    AST_SPLIT_WRAP: assert property (@(posedge clk) disable iff (rst)
        $past(lo_ovf && split_mode) |-> low_q == '0);                     // R7
    AST_HIGH_WRAP: assert property (@(posedge clk) disable iff (rst)
        $past(hi_ovf) |-> (high_q == '0 && ovf_flag[1]));                 // R8
    AST_HIGH_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(!(wr_en && wr_high) && !(split_mode && run_b && tick))
        |-> $stable(high_q));                                             // R6
    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        $past(lo_ovf) |-> ovf_flag[0]);                                   // R9
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(ovf_flag[0] && !flag_clr[0] && !irq_ack[0]) |-> ovf_flag[0]); // R9
    AST_NO_FLAG_B_RELOAD: assert property (@(posedge clk) disable iff (rst)
        $past(!split_mode && !ovf_flag[1]) |-> !ovf_flag[1]);             // R6
endmodule

bind tmr8_dual tmr8_dual_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .split_mode (split_mode),
    .run_b      (run_b),
    .wr_en      (wr_en),
    .wr_high    (wr_high),
    .wr_data    (wr_data),
    .flag_clr   (flag_clr),
    .irq_ack    (irq_ack),
    .low_q      (low_q),
    .high_q     (high_q),
    .ovf_flag   (ovf_flag),
    .tick       (tick),
    .lo_ovf     (lo_ovf),
    .hi_ovf     (hi_ovf)
);

// File: tb/tmr8_dual_tb.sv
`timescale 1ns/1ps
module tmr8_dual_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       split_mode = 1'b0, src_pin = 1'b0, gate_en = 1'b0;
    logic       run_a = 1'b0, run_b = 1'b0, cnt_pin = 1'b1, gate_pin = 1'b0;
    logic       wr_en = 1'b0, wr_high = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] flag_clr = 2'b00, irq_ack = 2'b00;
    logic [7:0] low_q, high_q;
    logic [1:0] ovf_flag;

    always #10 clk = ~clk;

    tmr8_dual u_dut (
        .clk(clk), .rst(rst), .split_mode(split_mode), .src_pin(src_pin),
        .gate_en(gate_en), .run_a(run_a), .run_b(run_b), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .wr_en(wr_en), .wr_high(wr_high), .wr_data(wr_data),
        .flag_clr(flag_clr), .irq_ack(irq_ack), .low_q(low_q), .high_q(high_q),
        .ovf_flag(ovf_flag)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;

    // Reference model built from the requirements
    logic [7:0] m_lo = 8'h00, m_hi = 8'h00;
    logic       m_fa = 1'b0, m_fb = 1'b0;
    logic       m_s1 = 1'b0, m_s2 = 1'b0, m_s3 = 1'b0;
    int         m_ph = 0;

    always @(posedge clk) begin
        logic fall, tk, en, inc_lo, inc_hi, set_a, set_b;
        logic [7:0] nl, nh;
        if (rst) begin
            m_lo = 8'h00; m_hi = 8'h00; m_fa = 1'b0; m_fb = 1'b0;
            m_s1 = 1'b0; m_s2 = 1'b0; m_s3 = 1'b0; m_ph = 0;
        end else begin
            fall   = m_s3 && !m_s2;
            tk     = (m_ph == 5);
            en     = run_a && (!gate_en || gate_pin);
            inc_lo = en && (src_pin ? fall : tk);
            inc_hi = split_mode && run_b && tk;
            set_a  = 1'b0;
            set_b  = 1'b0;
            nl = m_lo;
            if (wr_en && !wr_high) nl = wr_data;
            else if (inc_lo) begin
                if (m_lo == 8'hFF) begin nl = split_mode ? 8'h00 : m_hi; set_a = 1'b1; end
                else nl = m_lo + 8'h01;
            end
            nh = m_hi;
            if (wr_en && wr_high) nh = wr_data;
            else if (inc_hi) begin
                if (m_hi == 8'hFF) begin nh = 8'h00; set_b = 1'b1; end
                else nh = m_hi + 8'h01;
            end
            m_fa = set_a || (m_fa && !(flag_clr[0] || irq_ack[0]));
            m_fb = set_b || (m_fb && !(flag_clr[1] || irq_ack[1]));
            m_lo = nl;
            m_hi = nh;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = cnt_pin;
            m_ph = tk ? 0 : m_ph + 1;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            checks++;
            if (low_q !== m_lo || high_q !== m_hi || ovf_flag !== {m_fb, m_fa}) begin
                fails++;
                $display("FAIL %s: lo=%h hi=%h flags=%b expected lo=%h hi=%h flags=%b",
                         cur_req, low_q, high_q, ovf_flag, m_lo, m_hi, {m_fb, m_fa});
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_wr(input logic hi, input logic [7:0] d);
        wr_en = 1'b1; wr_high = hi; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic clear_flags();
        flag_clr = 2'b11;
        step(1);
        flag_clr = 2'b00;
    endtask

    // Cycles between two successive sets of flag idx, acknowledging each
    task automatic measure(input int idx, input int limit, output int gap);
        int t0 = -1;
        gap = -1;
        for (int n = 1; n <= limit; n++) begin
            step(1);
            irq_ack = 2'b00;
            if (ovf_flag[idx]) begin
                irq_ack[idx] = 1'b1;
                if (t0 < 0) t0 = n;
                else begin gap = n - t0; break; end
            end
        end
        step(1);
        irq_ack = 2'b00;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int v0, gap;
        void'($urandom(32'h5EED_0617));

        // R1: reset state
        step(3);
        chk("R1", low_q, 0);
        chk("R1", high_q, 0);
        chk("R1", ovf_flag, 0);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R2: clock source, 10 counts per 60 cycles
        cur_req = "R2";
        cpu_wr(1'b0, 8'h00);
        run_a = 1'b1;
        v0 = low_q;
        step(60);
        chk("R2", low_q - v0, 10);

        // R4: gate qualification and run enable
        cur_req = "R4";
        gate_en = 1'b1; gate_pin = 1'b0;
        cpu_wr(1'b0, 8'h00);
        step(60);
        chk("R4", low_q, 0);
        gate_pin = 1'b1;
        step(60);
        chk("R4", low_q, 10);
        run_a = 1'b0; gate_en = 1'b0;
        step(30);
        chk("R4", low_q, 10);

        // R5: reload period 6*(256-0xF0) = 96
        cur_req = "R5";
        cpu_wr(1'b1, 8'hF0);
        cpu_wr(1'b0, 8'hF0);
        clear_flags();
        run_a = 1'b1;
        measure(0, 400, gap);
        chk("R5", gap, 96);

        // R6: high byte and second flag untouched in reload mode
        cur_req = "R6";
        run_b = 1'b1;
        step(100);
        chk("R6", high_q, 'hF0);
        chk("R6", ovf_flag[1], 0);
        run_a = 1'b0; run_b = 1'b0;

        // R3: pin source, three-edge latency, only falls count
        cur_req = "R3";
        src_pin = 1'b1; cnt_pin = 1'b1; run_a = 1'b1;
        step(4);
        cpu_wr(1'b0, 8'h10);
        cnt_pin = 1'b0;
        step(2);
        chk("R3", low_q, 'h10);
        step(1);
        chk("R3", low_q, 'h11);
        cnt_pin = 1'b1;
        step(6);
        chk("R3", low_q, 'h11);
        run_a = 1'b0; src_pin = 1'b0;

        // R7: split mode low byte wraps to zero
        cur_req = "R7";
        split_mode = 1'b1;
        clear_flags();
        cpu_wr(1'b0, 8'hFE);
        run_a = 1'b1;
        for (int n = 0; n < 20; n++) begin
            if (ovf_flag[0]) break;
            step(1);
        end
        chk("R7", ovf_flag[0], 1);
        chk("R7", low_q, 0);
        run_a = 1'b0;

        // R8: high byte period 6*256 with pin controls set against it
        cur_req = "R8";
        src_pin = 1'b1; gate_en = 1'b1; gate_pin = 1'b0; cnt_pin = 1'b0;
        clear_flags();
        run_b = 1'b1;
        measure(1, 4000, gap);
        chk("R8", gap, 1536);

        // R9: flag sticks until cleared
        cur_req = "R9";
        cpu_wr(1'b1, 8'hFF);
        step(8);
        run_b = 1'b0;
        step(30);
        chk("R9", ovf_flag[1], 1);
        flag_clr = 2'b10;
        step(1);
        flag_clr = 2'b00;
        chk("R9", ovf_flag[1], 0);
        src_pin = 1'b0; gate_en = 1'b0;

        // R10 / R11: random runs against the model
        for (int w = 0; w < 8; w++) begin
            cur_req    = (w < 4) ? "R10" : "R11";
            split_mode = 1'($urandom % 2);
            src_pin    = 1'($urandom % 2);
            gate_en    = 1'($urandom % 2);
            run_a      = 1'b1;
            run_b      = 1'b1;
            for (int c = 0; c < 1500; c++) begin
                step(1);
                wr_en    = (($urandom % ((w < 4) ? 12 : 60)) == 0);
                wr_high  = 1'($urandom % 2);
                wr_data  = (($urandom % 3) == 0) ? 8'hFF : 8'($urandom);
                if (($urandom % 3) == 0) cnt_pin = ~cnt_pin;
                if (($urandom % 8) == 0) gate_pin = ~gate_pin;
                flag_clr = (($urandom % 20) == 0) ? 2'($urandom) : 2'b00;
                irq_ack  = (($urandom % 20) == 0) ? 2'($urandom) : 2'b00;
                if (($urandom % 100) == 0) run_a = ~run_a;
                if (($urandom % 100) == 0) run_b = ~run_b;
            end
        end
        wr_en = 1'b0; flag_clr = 2'b00; irq_ack = 2'b00;
        step(2);
        cmp_on = 1'b0;
        summary();
        $finish;
    end
endmodule